// File: doc/BRIEF.md
# Byte-Counted Audio DMA Channel

This block is a single DMA channel that moves audio bytes between system memory and a sample stream. One parameter picks the direction. In playback it reads words from memory and pushes them to the outgoing stream. In record it takes words from the incoming stream and writes them to memory.

The register block loads a start byte address and a byte count while the channel is idle, and supplies an enable bit. On each service request the channel computes a budget. The budget is the smaller of the remaining count and the stream's current byte level, which means free space in playback and buffered data in record. The channel then works through the budget in chunks no larger than a fixed size. Before each chunk it reads the stream level again, and a zero level ends the transfer early without any error. Every beat moves one 32-bit word over a valid/ready memory handshake. When fewer than four bytes remain, the beat carries a partial byte mask.

When the transfer ends, the channel writes back the address and the count. If the channel is still enabled and the count has reached zero, it raises a one-cycle completion interrupt. The stream carries 48 kHz stereo signed 16-bit samples, so one frame is four bytes, and normal buffers are multiples of the word size.

Top module: `audio_dma_chan`

## Requirements
- R1: After a synchronous reset, the following are all zero or low: `cur_addr`, `cur_count`, `busy`, `irq_done`, `mem_valid`, `stm_out_valid` and `stm_in_pop`.
- R2: While the channel is idle, `cfg_load` copies `cfg_addr` and `cfg_count` into `cur_addr` and `cur_count` on the next edge. While `busy` is high, `cfg_load` has no effect on the final address or count.
- R3: A `svc_req` is ignored when `cfg_enable` is low. When enabled, the budget is min(`cur_count`, `stm_level`). A zero budget changes no state, leaves `busy` low and raises no interrupt.
- R4: Each chunk is min(budget left, `CHUNK_BYTES`, `stm_level` sampled at the chunk start). A zero chunk ends the transfer early and keeps the bytes moved so far.
- R5: Each beat holds `mem_valid`, `mem_addr` and `mem_be` stable until `mem_ready`. Beats advance the byte address by the bytes moved. A beat of n bytes drives the lowest n lanes of `mem_be` (patterns 0001, 0011, 0111, 1111).
- R6: At the end of a transfer, `cur_addr` increases by the total bytes moved and `cur_count` decreases by the same total. `busy` stays high from the service start until this write-back.
- R7: `irq_done` pulses for exactly one cycle, on the edge where `busy` falls. It pulses only if `cfg_enable` is high and `cur_count` has become zero.
- R8: In playback, every accepted beat is followed on the next cycle by `stm_out_valid`. That cycle carries the read word on `stm_out_data` and the beat's mask on `stm_out_be`, in ascending address order.
- R9: In record, `mem_write` is high and `mem_wdata` is the head word `stm_in_data`. `stm_in_pop` is high in each cycle where a beat is accepted.
- R10: Clearing `cfg_enable` mid-transfer stops the channel at the next beat boundary. The write-back keeps the progress made so far, and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Channel enable |
| cfg_load | input | 1 | Load address and count (idle only) |
| cfg_addr | input | ADDR_W | Start byte address to load |
| cfg_count | input | CNT_W | Byte count to load |
| svc_req | input | 1 | Service opportunity pulse |
| stm_level | input | CNT_W | Stream bytes free (playback) or available (record) |
| busy | output | 1 | Transfer in progress |
| irq_done | output | 1 | One-cycle completion interrupt |
| cur_addr | output | ADDR_W | Current byte address |
| cur_count | output | CNT_W | Remaining byte count |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory beat accepted |
| mem_write | output | 1 | Beat is a write (record) |
| mem_addr | output | ADDR_W | Beat byte address |
| mem_be | output | 4 | Beat byte lanes |
| mem_wdata | output | 32 | Write data (record) |
| mem_rdata | input | 32 | Read data, valid with mem_ready (playback) |
| stm_out_valid | output | 1 | Word pushed to output stream (playback) |
| stm_out_data | output | 32 | Pushed word |
| stm_out_be | output | 4 | Valid lanes of pushed word |
| stm_in_data | input | 32 | Head word of input stream (record) |
| stm_in_pop | output | 1 | Consume head word (record) |

## Verification
The assertions check several things on every cycle:
- the completion pulse is one cycle long, appears only with the enable set and only at a zero count;
- a stalled beat holds its address and mask;
- the mask is always a contiguous low-lane pattern;
- no beat is requested while the channel is idle;
- the count never grows during a transfer.

Other properties are end-to-end and only the bench's scenarios can show them:
- the budget arithmetic across a sweep of counts and stream levels;
- the early stop when the stream level drops to zero;
- the stop at a beat boundary when the enable is cleared;
- a load request arriving mid-transfer being ignored;
- the word order and data on both stream directions.

// File: rtl/adma_pkg.sv
package adma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHUNK,
    ST_LAUNCH,
    ST_BEAT,
    ST_WB
  } adma_state_e;

  localparam int LANES  = 4;
  localparam int WORD_W = 32;
endpackage

// File: rtl/adma_min3.sv
module adma_min3 #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  logic [W-1:0] ab;
  always_comb begin
    ab = (a < b) ? a : b;
    y  = (ab < c) ? ab : c;
  end
endmodule

// File: rtl/adma_lane_mask.sv
module adma_lane_mask #(
  parameter int W     = 16,
  parameter int LANES = 4
) (
  input  logic [W-1:0]     left,
  output logic [LANES-1:0] mask,
  output logic [W-1:0]     nbytes
);
  localparam logic [W-1:0] LANES_W = W'(LANES);

  assign nbytes = (left > LANES_W) ? LANES_W : left;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask[i] = (nbytes > W'(i));
  end
endmodule

// File: rtl/adma_stream_port.sv
module adma_stream_port #(
  parameter bit IS_PLAYBACK = 1'b1,
  parameter int DATA_W      = 32,
  parameter int LANES       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat_fire,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [LANES-1:0]  beat_be,
  input  logic [DATA_W-1:0] stm_in_data,
  output logic              stm_out_valid,
  output logic [DATA_W-1:0] stm_out_data,
  output logic [LANES-1:0]  stm_out_be,
  output logic              stm_in_pop,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_write
);
  if (IS_PLAYBACK) begin : g_play
    logic              vld_q;
    logic [DATA_W-1:0] dat_q;
    logic [LANES-1:0]  be_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= 1'b0;
        dat_q <= '0;
        be_q  <= '0;
      end else begin
        vld_q <= beat_fire;
        if (beat_fire) begin
          dat_q <= mem_rdata;
          be_q  <= beat_be;
        end
      end
    end
    logic unused_rec;
    assign unused_rec    = ^stm_in_data;
    assign stm_out_valid = vld_q;
    assign stm_out_data  = dat_q;
    assign stm_out_be    = be_q;
    assign stm_in_pop    = 1'b0;
    assign mem_wdata     = '0;
    assign mem_write     = 1'b0;
  end else begin : g_rec
    logic unused_play;
    assign unused_play   = ^{clk, rst, mem_rdata, beat_be};
    assign stm_out_valid = 1'b0;
    assign stm_out_data  = '0;
    assign stm_out_be    = '0;
    assign stm_in_pop    = beat_fire;
    assign mem_wdata     = stm_in_data;
    assign mem_write     = 1'b1;
  end
endmodule

// File: rtl/audio_dma_chan.sv
module audio_dma_chan
  import adma_pkg::*;
#(
  parameter bit IS_PLAYBACK = 1'b1,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int CHUNK_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              svc_req,
  input  logic [CNT_W-1:0]  stm_level,
  output logic              busy,
  output logic              irq_done,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_count,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              stm_out_valid,
  output logic [31:0]       stm_out_data,
  output logic [3:0]        stm_out_be,
  input  logic [31:0]       stm_in_data,
  output logic              stm_in_pop
);
  localparam logic [CNT_W-1:0] CHUNK_C = CNT_W'(CHUNK_BYTES);

  adma_state_e       state_q;
  logic [ADDR_W-1:0] addr_q, mem_addr_q;
  logic [CNT_W-1:0]  count_q, budget_left_q, chunk_left_q, moved_q, beat_n_q;
  logic              mem_valid_q, busy_q, irq_q;
  logic [LANES-1:0]  mem_be_q;

  logic [CNT_W-1:0]  budget_now, chunk_now, lane_n;
  logic [LANES-1:0]  lane_mask;
  logic              beat_fire;

  adma_min3 #(.W(CNT_W)) u_budget (
    .a(count_q), .b(stm_level), .c({CNT_W{1'b1}}), .y(budget_now)
  );

  adma_min3 #(.W(CNT_W)) u_chunk (
    .a(budget_left_q), .b(CHUNK_C), .c(stm_level), .y(chunk_now)
  );

  adma_lane_mask #(.W(CNT_W), .LANES(LANES)) u_mask (
    .left(chunk_left_q), .mask(lane_mask), .nbytes(lane_n)
  );

  assign beat_fire = mem_valid_q & mem_ready;

  adma_stream_port #(.IS_PLAYBACK(IS_PLAYBACK), .DATA_W(WORD_W), .LANES(LANES)) u_port (
    .clk(clk), .rst(rst), .beat_fire(beat_fire), .mem_rdata(mem_rdata),
    .beat_be(mem_be_q), .stm_in_data(stm_in_data),
    .stm_out_valid(stm_out_valid), .stm_out_data(stm_out_data),
    .stm_out_be(stm_out_be), .stm_in_pop(stm_in_pop),
    .mem_wdata(mem_wdata), .mem_write(mem_write)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      addr_q        <= '0;
      count_q       <= '0;
      budget_left_q <= '0;
      chunk_left_q  <= '0;
      moved_q       <= '0;
      beat_n_q      <= '0;
      mem_valid_q   <= 1'b0;
      mem_addr_q    <= '0;
      mem_be_q      <= '0;
      busy_q        <= 1'b0;
      irq_q         <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (cfg_load) begin
            addr_q  <= cfg_addr;
            count_q <= cfg_count;
          end else if (svc_req && cfg_enable && (budget_now != '0)) begin
            budget_left_q <= budget_now;
            moved_q       <= '0;
            busy_q        <= 1'b1;
            state_q       <= ST_CHUNK;
          end
        end
        ST_CHUNK: begin
          if (!cfg_enable || (chunk_now == '0)) begin
            state_q <= ST_WB;
          end else begin
            chunk_left_q <= chunk_now;
            state_q      <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: begin
          mem_valid_q <= 1'b1;
          mem_addr_q  <= addr_q + ADDR_W'(moved_q);
          mem_be_q    <= lane_mask;
          beat_n_q    <= lane_n;
          state_q     <= ST_BEAT;
        end
        ST_BEAT: begin
          if (beat_fire) begin
            mem_valid_q   <= 1'b0;
            moved_q       <= moved_q + beat_n_q;
            budget_left_q <= budget_left_q - beat_n_q;
            chunk_left_q  <= chunk_left_q - beat_n_q;
            if (!cfg_enable || (budget_left_q == beat_n_q)) begin
              state_q <= ST_WB;
            end else if (chunk_left_q == beat_n_q) begin
              state_q <= ST_CHUNK;
            end else begin
              state_q <= ST_LAUNCH;
            end
          end
        end
        ST_WB: begin
          addr_q  <= addr_q + ADDR_W'(moved_q);
          count_q <= count_q - moved_q;
          irq_q   <= cfg_enable && (count_q == moved_q);
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = busy_q;
  assign irq_done  = irq_q;
  assign cur_addr  = addr_q;
  assign cur_count = count_q;
  assign mem_valid = mem_valid_q;
  assign mem_addr  = mem_addr_q;
  assign mem_be    = mem_be_q;
endmodule

// File: rtl/adma_chan_checker.sv
module adma_chan_checker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_enable,
  input logic              busy,
  input logic              irq_done,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic [CNT_W-1:0]  cur_count
);
  assert_irq_single_R7: assert property (@(posedge clk) disable iff (rst)
    irq_done |=> !irq_done);

  assert_irq_enabled_R7: assert property (@(posedge clk) disable iff (rst)
    irq_done |-> $past(cfg_enable));

  assert_irq_at_zero_R7: assert property (@(posedge clk) disable iff (rst)
    irq_done |-> (cur_count == '0));

  assert_beat_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_be)));

  assert_mask_shape_R5: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_be == 4'b0001 || mem_be == 4'b0011 ||
                   mem_be == 4'b0111 || mem_be == 4'b1111));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_valid);

  assert_count_down_R6: assert property (@(posedge clk) disable iff (rst)
    busy |=> (cur_count <= $past(cur_count)));
endmodule

bind audio_dma_chan adma_chan_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .busy(busy),
  .irq_done(irq_done), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_be(mem_be), .cur_count(cur_count)
);

// File: tb/audio_dma_chan_tb.sv
module audio_dma_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CHUNK      = 16;
  localparam int WIN        = 100;
  localparam logic [31:0] PAT = 32'h5A5A_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  // playback channel
  logic        en_base = 1'b0, kill_en = 1'b0, cfg_enable;
  logic        cfg_load = 1'b0, svc_req = 1'b0;
  logic [31:0] cfg_addr = '0;
  logic [15:0] cfg_count = '0, level_base = '0, stm_level;
  logic        kill_lvl = 1'b0, arm_lvl = 1'b0, arm_en = 1'b0;
  logic        busy, irq_done, mem_valid, mem_write, stm_out_valid, stm_in_pop;
  logic        mem_ready = 1'b1;
  logic [31:0] cur_addr, mem_addr, mem_wdata, mem_rdata, stm_out_data;
  logic [15:0] cur_count;
  logic [3:0]  mem_be, stm_out_be;

  assign cfg_enable = en_base & ~kill_en;
  assign stm_level  = kill_lvl ? 16'd0 : level_base;
  assign mem_rdata  = mem_addr ^ PAT;

  audio_dma_chan #(.IS_PLAYBACK(1'b1), .CHUNK_BYTES(CHUNK)) u_dut (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_load(cfg_load),
    .cfg_addr(cfg_addr), .cfg_count(cfg_count), .svc_req(svc_req),
    .stm_level(stm_level), .busy(busy), .irq_done(irq_done),
    .cur_addr(cur_addr), .cur_count(cur_count), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .stm_out_valid(stm_out_valid), .stm_out_data(stm_out_data),
    .stm_out_be(stm_out_be), .stm_in_data(32'h0), .stm_in_pop(stm_in_pop)
  );

  // record channel
  logic        r_en = 1'b0, r_load = 1'b0, r_svc = 1'b0;
  logic [31:0] r_cfg_addr = '0, r_addr, r_maddr, r_wdata, r_sodata;
  logic [15:0] r_cfg_count = '0, r_level = '0, r_count;
  logic        r_busy, r_irq, r_valid, r_write, r_sovalid, r_pop;
  logic [3:0]  r_be, r_sobe;
  logic [31:0] rec_word = 32'hC0DE_0000;

  audio_dma_chan #(.IS_PLAYBACK(1'b0), .CHUNK_BYTES(CHUNK)) u_rec (
    .clk(clk), .rst(rst), .cfg_enable(r_en), .cfg_load(r_load),
    .cfg_addr(r_cfg_addr), .cfg_count(r_cfg_count), .svc_req(r_svc),
    .stm_level(r_level), .busy(r_busy), .irq_done(r_irq),
    .cur_addr(r_addr), .cur_count(r_count), .mem_valid(r_valid),
    .mem_ready(1'b1), .mem_write(r_write), .mem_addr(r_maddr),
    .mem_be(r_be), .mem_wdata(r_wdata), .mem_rdata(32'h0),
    .stm_out_valid(r_sovalid), .stm_out_data(r_sodata),
    .stm_out_be(r_sobe), .stm_in_data(rec_word), .stm_in_pop(r_pop)
  );

  always @(posedge clk) if (r_pop) rec_word <= rec_word + 32'd1;

  int checks = 0, fails = 0;
  int mon_checks = 0, mon_fails = 0, wd_fail = 0;
  int pushed = 0, irq_cnt = 0, cyc = 0, exp_total = 0;
  int rbytes = 0, r_irq_cnt = 0;
  logic saw_busy = 1'b0, mon_clear = 1'b0;
  logic [31:0] base_a = '0;

  function automatic logic [3:0] exp_mask(int n);
    if (n >= 4) return 4'hF;
    if (n <= 0) return 4'h0;
    return 4'((1 << n) - 1);
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  // monitor: samples a quarter period after the rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    cyc++;
    mem_ready = (cyc % 3) != 0;
    if (mon_clear) begin
      pushed = 0; irq_cnt = 0; saw_busy = 1'b0; kill_lvl = 1'b0; kill_en = 1'b0;
    end else if (!rst) begin
      if (busy) saw_busy = 1'b1;
      if (irq_done) irq_cnt++;
      if (stm_out_valid) begin
        mon_checks++;
        if (stm_out_be !== exp_mask(exp_total - pushed) ||
            stm_out_data !== ((base_a + 32'(pushed)) ^ PAT)) begin
          mon_fails++;
          $display("FAIL R8/R5 push: data=%h be=%b expected data=%h be=%b",
                   stm_out_data, stm_out_be, (base_a + 32'(pushed)) ^ PAT,
                   exp_mask(exp_total - pushed));
        end
        pushed += $countones(stm_out_be);
        if (arm_lvl) kill_lvl = 1'b1;
        if (arm_en)  kill_en  = 1'b1;
      end
    end
    if (!rst) begin
      if (r_irq) r_irq_cnt++;
      if (r_valid) begin
        mon_checks++;
        if (r_wdata !== rec_word || r_be !== exp_mask(10 - rbytes) ||
            r_maddr !== 32'h200 + 32'(rbytes) || r_write !== 1'b1) begin
          mon_fails++;
          $display("FAIL R9 record beat: wdata=%h be=%b addr=%h expected wdata=%h be=%b addr=%h",
                   r_wdata, r_be, r_maddr, rec_word, exp_mask(10 - rbytes),
                   32'h200 + 32'(rbytes));
        end
        rbytes += $countones(r_be);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input logic [31:0] a0, input int r0, input int lvl,
                          input bit en, input bit mid_load);
    @(negedge clk);
    cfg_addr = a0; cfg_count = 16'(r0); cfg_load = 1'b1; mon_clear = 1'b1;
    base_a = a0; level_base = 16'(lvl); en_base = en;
    exp_total = en ? imin(r0, lvl) : 0;
    @(negedge clk);
    cfg_load = 1'b0; mon_clear = 1'b0;
    chk(cur_addr == a0 && cur_count == 16'(r0), "R2 load", longint'(cur_count), longint'(r0));
    svc_req = 1'b1;
    @(negedge clk);
    svc_req = 1'b0;
    if (mid_load) begin
      repeat (4) @(negedge clk);
      cfg_addr = 32'hFFF0; cfg_count = 16'd7; cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
    end
    repeat (WIN) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
             checks + mon_checks, fails + mon_fails + wd_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    wd_fail = 1;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int rs[12];
    int ls[6];
    rs = '{0, 1, 2, 3, 4, 5, 7, 8, 15, 16, 17, 33};
    ls = '{0, 3, 4, 16, 20, 64};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cur_addr == 0 && cur_count == 0, "R1 addr/count", longint'(cur_count), 0);
    chk(!busy && !irq_done && !mem_valid && !stm_out_valid && !r_pop, "R1 flags",
        longint'({busy, irq_done, mem_valid, stm_out_valid}), 0);

    // R3 R6 R7 R8 sweep over count and stream level
    for (int i = 0; i < 12; i++) begin
      for (int j = 0; j < 6; j++) begin
        int e;
        e = imin(rs[i], ls[j]);
        run_case(32'h1000, rs[i], ls[j], 1'b1, 1'b0);
        chk(cur_addr == 32'h1000 + 32'(e), "R6 addr", longint'(cur_addr), longint'(32'h1000 + e));
        chk(cur_count == 16'(rs[i] - e), "R6 count", longint'(cur_count), longint'(rs[i] - e));
        chk(pushed == e, "R8 bytes pushed", pushed, e);
        chk(irq_cnt == ((e == rs[i] && e > 0) ? 1 : 0), "R7 irq", irq_cnt,
            (e == rs[i] && e > 0) ? 1 : 0);
        chk(saw_busy == (e > 0), "R3 busy on zero budget", longint'(saw_busy), longint'(e > 0));
      end
    end

    // R3 disabled channel ignores service
    run_case(32'h2000, 20, 20, 1'b0, 1'b0);
    chk(pushed == 0 && cur_count == 20 && !saw_busy && irq_cnt == 0, "R3 disabled",
        pushed, 0);

    // R4 early stop when the stream level drops to zero after the first chunk
    arm_lvl = 1'b1;
    run_case(32'h3000, 40, 40, 1'b1, 1'b0);
    arm_lvl = 1'b0;
    chk(pushed == CHUNK, "R4 early stop bytes", pushed, CHUNK);
    chk(cur_count == 16'(40 - CHUNK), "R4 early stop count", longint'(cur_count), 40 - CHUNK);
    chk(irq_cnt == 0, "R4 no irq", irq_cnt, 0);

    // R10 enable cleared during the transfer
    arm_en = 1'b1;
    run_case(32'h4000, 40, 40, 1'b1, 1'b0);
    arm_en = 1'b0;
    chk(pushed > 0 && pushed < 40 && (pushed % 4) == 0, "R10 partial progress", pushed, 8);
    chk(cur_count == 16'(40 - pushed) && cur_addr == 32'h4000 + 32'(pushed),
        "R10 write-back kept", longint'(cur_count), longint'(40 - pushed));
    chk(irq_cnt == 0, "R10 no irq", irq_cnt, 0);

    // R2 load request during a transfer is ignored
    run_case(32'h5000, 24, 64, 1'b1, 1'b1);
    chk(cur_addr == 32'h5018, "R2 busy load ignored addr", longint'(cur_addr), 32'h5018);
    chk(cur_count == 0 && irq_cnt == 1, "R2 busy load ignored count", longint'(cur_count), 0);

    // R9 record direction
    @(negedge clk);
    r_cfg_addr = 32'h200; r_cfg_count = 16'd10; r_load = 1'b1; r_en = 1'b1; r_level = 16'd20;
    @(negedge clk);
    r_load = 1'b0; r_svc = 1'b1;
    @(negedge clk);
    r_svc = 1'b0;
    repeat (WIN) @(negedge clk);
    chk(rbytes == 10, "R9 record bytes", rbytes, 10);
    chk(r_addr == 32'h20A && r_count == 0, "R9 record write-back", longint'(r_addr), 32'h20A);
    chk(rec_word == 32'hC0DE_0003, "R9 record pops", longint'(rec_word), 32'hC0DE_0003);
    chk(r_irq_cnt == 1, "R7 record irq", r_irq_cnt, 1);

    finish_run();
  end
endmodule